// File: doc/BRIEF.md
# Double Pulse Gate Sequencer

This block produces the gate command for a double pulse switching test of a power device. When a start request is accepted, it turns the gate on and keeps it on until an external comparator flag reports that the load inductor current has reached the test level. It then holds the gate off for a programmed freewheel gap. This gap is long enough for the ringing to settle and short enough that the inductor current barely decays. Next it drives a second on-pulse of programmed length, which captures the turn-on transient. Finally it forces the gate low and reports completion.

Each accepted start runs one sequence only. This keeps the device from self-heating between test conditions. A new sequence needs a fresh start request after the previous one has been released. A ceiling on the first pulse length guards against a current flag that never arrives. An abort input stops the sequence in any phase.

Top module: `dp_gate_seq`

## Requirements
- R1: After reset, gate_o, busy_o, done_o and fault_o are all low.
- R2: A start is accepted when start_i is high, the block is idle, abort_i is low and the block is armed. In the cycle after acceptance, gate_o and busy_o are both high.
- R3: The first pulse ends on the flag. If cur_hit_i is sampled high in the k-th cycle of the first pulse, gate_o stays high for exactly k cycles. When the flag and the ceiling fall on the same cycle, the flag wins.
- R4: If cur_hit_i stays low for hold_max_i first-pulse cycles, gate_o falls after exactly hold_max_i cycles. In that same cycle busy_o falls and fault_o rises, and no second pulse follows.
- R5: After a flag-terminated first pulse, gate_o stays low for gap_len_i cycles. A value of 0 counts as 1.
- R6: The second pulse keeps gate_o high for pulse2_len_i cycles. A value of 0 counts as 1. In the cycle after it ends, gate_o and busy_o are low and done_o is high.
- R7: gap_len_i, pulse2_len_i and hold_max_i are captured when a start is accepted. Changes to them during a sequence have no effect on it.
- R8: abort_i high in any cycle makes gate_o, busy_o and done_o low in the next cycle. Abort also blocks a start request in the same cycle.
- R9: Accepting a start disarms the block. The block is re-armed only by a cycle with start_i low, so holding start_i high never begins a second sequence.
- R10: gate_o is high only in the two pulse phases. Accepting a start clears done_o and fault_o, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, level |
| abort_i | input | 1 | Abort, stops the sequence |
| cur_hit_i | input | 1 | Comparator flag: load current at test level |
| hold_max_i | input | CW | First pulse ceiling, in cycles |
| gap_len_i | input | CW | Freewheel gap, in cycles |
| pulse2_len_i | input | CW | Second pulse length, in cycles |
| gate_o | output | 1 | Registered gate command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence completed normally |
| fault_o | output | 1 | Last sequence hit the first pulse ceiling |

## Verification
The bench measures the lengths of the high, low and high runs of the gate and compares them with the programmed counts. A timer that is off by one would lengthen or shorten a run. The bench also drives the flag in the very cycle the ceiling expires. A design that gives the ceiling priority would report a fault for a test that reached its current.

The bench changes the counts right after acceptance to catch a design that reads them live. It holds start high across completion to catch a block that re-triggers and heats the device. It aborts in each phase, and together with a start request, to catch a gate that lingers or a sequence that slips through.

// File: rtl/dp_seq_pkg.sv
package dp_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_P1   = 2'd1,
    ST_GAP  = 2'd2,
    ST_P2   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dp_start_guard.sv
module dp_start_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic idle_i,
  input  logic abort_i,
  output logic accept_o
);
  logic armed_q;

  assign accept_o = start_i && armed_q && idle_i && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b1;
    else if (accept_o)   armed_q <= 1'b0;
    else if (!start_i)   armed_q <= 1'b1;
  end
endmodule

// File: rtl/dp_interval_timer.sv
module dp_interval_timer #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          last_o
);
  localparam int EW = CW + 1;
  logic [CW-1:0] cnt_q;
  logic [EW-1:0] cnt_next;

  assign cnt_next = {1'b0, cnt_q} + EW'(1);
  // zero limit behaves as one cycle
  assign last_o   = cnt_next >= {1'b0, limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (!last_o) cnt_q <= cnt_next[CW-1:0];
  end
endmodule

// File: rtl/dp_gate_seq.sv
module dp_gate_seq
  import dp_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          cur_hit_i,
  input  logic [CW-1:0] hold_max_i,
  input  logic [CW-1:0] gap_len_i,
  input  logic [CW-1:0] pulse2_len_i,
  output logic          gate_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fault_o
);
  seq_state_e    state_q, state_d;
  logic [CW-1:0] hold_q, gap_q, p2_q, limit;
  logic          accept, last, tmr_clr, timeout, finish;
  logic          gate_q, done_q, fault_q;

  dp_start_guard u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .idle_i   (state_q == ST_IDLE),
    .abort_i  (abort_i),
    .accept_o (accept)
  );

  always_comb begin
    unique case (state_q)
      ST_P1:   limit = hold_q;
      ST_GAP:  limit = gap_q;
      default: limit = p2_q;
    endcase
  end

  dp_interval_timer #(.CW(CW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .limit_i (limit),
    .last_o  (last)
  );

  always_comb begin
    state_d = state_q;
    timeout = 1'b0;
    finish  = 1'b0;
    if (abort_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) state_d = ST_P1;
        ST_P1: begin
          // flag has priority over the ceiling
          if (cur_hit_i) state_d = ST_GAP;
          else if (last) begin
            state_d = ST_IDLE;
            timeout = 1'b1;
          end
        end
        ST_GAP: if (last) state_d = ST_P2;
        ST_P2: begin
          if (last) begin
            state_d = ST_IDLE;
            finish  = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign tmr_clr = state_d != state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gate_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      hold_q  <= '0;
      gap_q   <= '0;
      p2_q    <= '0;
    end else begin
      state_q <= state_d;
      gate_q  <= (state_d == ST_P1) || (state_d == ST_P2);
      if (accept) begin
        hold_q <= hold_max_i;
        gap_q  <= gap_len_i;
        p2_q   <= pulse2_len_i;
      end
      if (accept || abort_i) done_q <= 1'b0;
      else if (finish)       done_q <= 1'b1;
      if (accept)            fault_q <= 1'b0;
      else if (timeout)      fault_q <= 1'b1;
    end
  end

  assign gate_o  = gate_q;
  assign busy_o  = state_q != ST_IDLE;
  assign done_o  = done_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/dp_gate_seq_chk.sv
module dp_gate_seq_chk
  import dp_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       abort_i,
  input logic       gate_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       fault_o,
  input seq_state_e state_q
);
  // R10
  gate_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> (state_q == ST_P1 || state_q == ST_P2));

  // R8
  abort_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!gate_o && !busy_o && !done_o));

  // R2
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(start_i) && gate_o));

  // R4
  fault_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> ($past(gate_o) && !gate_o && !busy_o));

  // R6
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(gate_o) && !gate_o && !busy_o));

  // R10
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
endmodule

bind dp_gate_seq dp_gate_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .abort_i (abort_i),
  .gate_o  (gate_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .fault_o (fault_o),
  .state_q (state_q)
);

// File: tb/dp_gate_seq_test.sv
`timescale 1ns/1ps
module dp_gate_seq_test;
  localparam int CW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, hit = 1'b0;
  logic [CW-1:0] hold_max = '0, gap_len = '0, p2_len = '0;
  logic gate, busy, done, fault;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dp_gate_seq #(.CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .cur_hit_i(hit), .hold_max_i(hold_max), .gap_len_i(gap_len),
    .pulse2_len_i(p2_len), .gate_o(gate), .busy_o(busy),
    .done_o(done), .fault_o(fault)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one sequence and measures the high, low and high runs of the gate.
  // Counts are scrambled right after acceptance (R7).
  task automatic run_seq(input int k, input int gp, input int p2, input int mx,
                         output int h1, output int l1, output int h2,
                         output int f0, output int dn, output int ft);
    int phase = 0;
    h1 = 0; l1 = 0; h2 = 0; f0 = 0;
    @(negedge clk);
    hold_max = CW'(mx); gap_len = CW'(gp); p2_len = CW'(p2);
    hit = 1'b0; start = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (n == 0) begin
        start = 1'b0;
        f0 = int'(done) + int'(fault);
        hold_max = 16'd9; gap_len = 16'd9; p2_len = 16'd9;
      end
      if (!busy) break;
      if (gate) begin
        if (phase == 0) h1++;
        else begin phase = 2; h2++; end
      end else begin
        if (phase == 0) phase = 1;
        if (phase == 1) l1++;
      end
      if (phase == 0 && k > 0 && h1 == k) hit = 1'b1;
    end
    hit = 1'b0;
    dn = int'(done); ft = int'(fault);
  endtask

  task automatic t_reset();
    chk("R1 gate", int'(gate), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 fault", int'(fault), 0);
  endtask

  task automatic t_normal(input int k, input int gp, input int p2, input int mx);
    int h1, l1, h2, f0, dn, ft;
    int egp = (gp == 0) ? 1 : gp;
    int ep2 = (p2 == 0) ? 1 : p2;
    run_seq(k, gp, p2, mx, h1, l1, h2, f0, dn, ft);
    chk("R3 first pulse", h1, k);
    chk("R5 gap", l1, egp);
    chk("R6 second pulse", h2, ep2);
    chk("R6 done", dn, 1);
    chk("R10 no fault", ft, 0);
    chk("R7 latched counts", h2 + l1, egp + ep2);
  endtask

  task automatic t_timeout(input int mx);
    int h1, l1, h2, f0, dn, ft;
    run_seq(0, 3, 3, mx, h1, l1, h2, f0, dn, ft);
    chk("R4 ceiling length", h1, mx);
    chk("R4 no second pulse", h2, 0);
    chk("R4 fault", ft, 1);
    chk("R4 no done", dn, 0);
    // next accept clears the flags (R10)
    run_seq(2, 1, 1, 8, h1, l1, h2, f0, dn, ft);
    chk("R10 flags cleared on accept", f0, 0);
    chk("R10 recovered run done", dn, 1);
  endtask

  task automatic t_abort(input int at);
    @(negedge clk);
    hold_max = 16'd20; gap_len = 16'd4; p2_len = 16'd4; start = 1'b1; hit = 1'b0;
    for (int n = 0; n < at; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (n == 1) hit = 1'b1;
    end
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0; hit = 1'b0;
    chk("R8 abort gate", int'(gate), 0);
    chk("R8 abort busy", int'(busy), 0);
    chk("R8 abort done", int'(done), 0);
    repeat (6) @(negedge clk);
    chk("R8 stays idle", int'(busy) + int'(gate), 0);
  endtask

  task automatic t_abort_vs_start();
    @(negedge clk);
    start = 1'b1; abort = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    chk("R8 abort blocks start", int'(busy), 0);
    chk("R8 abort blocks gate", int'(gate), 0);
  endtask

  task automatic t_rearm();
    @(negedge clk);
    hold_max = 16'd8; gap_len = 16'd2; p2_len = 16'd2; hit = 1'b1; start = 1'b1;
    @(negedge clk);
    chk("R2 accept gate", int'(gate), 1);
    chk("R2 accept busy", int'(busy), 1);
    for (int n = 0; n < 40 && busy; n++) @(negedge clk);
    chk("R9 done with start held", int'(done), 1);
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (busy || gate) chk("R9 held start ignored", int'(busy), 0);
    end
    chk("R9 still idle", int'(busy), 0);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 rearmed start", int'(busy), 1);
    for (int n = 0; n < 40 && busy; n++) @(negedge clk);
    hit = 1'b0;
    chk("R9 second run done", int'(done), 1);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal(3, 4, 2, 10);
    t_normal(1, 0, 0, 5);
    t_normal(5, 7, 3, 5);   // flag on the ceiling cycle
    t_normal(12, 1, 6, 40);
    t_timeout(6);
    t_timeout(1);
    t_abort(1);             // first pulse
    t_abort(4);             // gap
    t_abort(7);             // second pulse
    t_abort_vs_start();
    t_rearm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule